// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This unit performs a 64-bit shift in which the bit positions vacated in the destination operand are filled from a second source operand instead of with zeros. A direction select picks a left or a right funnel. The shift count comes either from an 8-bit immediate or from a count register value. Only the low six bits of the chosen count are used.

The result and the carry, overflow, zero, sign and parity flags are registered and appear one cycle after the valid strobe, together with a one-cycle output valid pulse. The unit also gives a result write-enable and one update enable for each flag. A masked count of zero is a no-op: the output valid still pulses, but nothing is written and no flag changes. Overflow is only defined, and only updated, for a count of exactly one. The registered flag state is kept between operations, so a flag whose enable is low keeps its earlier value at the outputs.

Top module: `funnel_shift`

## Requirements
- R1: The effective count is `(use_imm_i ? imm_i : cnt_reg_i) & 63`. Bits 7:6 of the chosen value have no effect.
- R2: When the effective count is 0, the output after that strobe has `valid_o`=1, `wr_en_o`=0 and `flag_we_o`=0. `result_o` and all flag outputs keep their previous values.
- R3: With `dir_i`=0 (left), the result is `(dst_i << c) | (src_i >> (64-c))` for c in 1..63.
- R4: With `dir_i`=1 (right), the result is `(dst_i >> c) | (src_i << (64-c))` for c in 1..63.
- R5: The carry flag is `dst_i[64-c]` on a left shift and `dst_i[c-1]` on a right shift.
- R6: For c=1, overflow is `result[63] ^ dst_i[63]` and `flag_we_o[1]`=1. For c>1, `flag_we_o[1]`=0 and `of_o` keeps its previous value.
- R7: The zero flag is 1 exactly when the result is zero. The sign flag equals `result[63]`. The parity flag is 1 when `result[7:0]` has an even number of ones.
- R8: For a nonzero count, `flag_we_o` is `{pf,sf,zf,of,cf}` enables (bit 0 = carry, bit 1 = overflow, bit 2 = zero, bit 3 = sign, bit 4 = parity) with bits 0, 2, 3 and 4 set, and `wr_en_o`=1.
- R9: All outputs appear in the cycle after `valid_i` is high. `valid_o` is high for exactly that one cycle. Without `valid_i`, `valid_o`, `wr_en_o` and `flag_we_o` are 0 and `result_o` and the flags hold.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| dir_i | input | 1 | 0 = left funnel, 1 = right funnel |
| use_imm_i | input | 1 | 1 = count from immediate, 0 = from count register |
| imm_i | input | 8 | Immediate count |
| cnt_reg_i | input | 8 | Count register value |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Fill source operand |
| valid_o | output | 1 | One-cycle result strobe |
| wr_en_o | output | 1 | Result write-enable |
| result_o | output | 64 | Shifted result |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Parity flag |
| flag_we_o | output | 5 | Per-flag update enables (bit 0 carry .. bit 4 parity) |

## Verification
The hardest situation to reach is an overflow value that survives. It needs a count-1 operation that sets `of_o`, followed by counts above one or a masked zero count whose own overflow would differ, and then a check that `of_o` did not move. The stimulus sweeps every count from 0 to 63 in both directions with random operands. It mixes in count-1 operations throughout, uses counts 64 and 65 to exercise the masking, and checks that an idle cycle leaves all state alone.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
  typedef enum logic {
    FSH_LEFT  = 1'b0,
    FSH_RIGHT = 1'b1
  } fsh_dir_e;

  // member order fixes the flag_we_o bit order: cf is bit 0
  typedef struct packed {
    logic pf;
    logic sf;
    logic zf;
    logic of;
    logic cf;
  } fsh_flags_t;
endpackage

// File: rtl/fsh_count_sel.sv
module fsh_count_sel #(
  parameter int IN_W = 8,
  parameter int W    = 64,
  localparam int CW  = $clog2(W)
) (
  input  logic            use_imm_i,
  input  logic [IN_W-1:0] imm_i,
  input  logic [IN_W-1:0] creg_i,
  output logic [CW-1:0]   cnt_o,
  output logic            zero_o,
  output logic            one_o
);
  logic [IN_W-1:0] sel;

  assign sel    = use_imm_i ? imm_i : creg_i;
  assign cnt_o  = CW'(sel & IN_W'(W - 1));
  assign zero_o = (cnt_o == '0);
  assign one_o  = (cnt_o == CW'(1));
endmodule

// File: rtl/fsh_core.sv
module fsh_core
  import funnel_pkg::*;
#(
  parameter int W   = 64,
  localparam int CW = $clog2(W),
  localparam int EW = 2 * W + 1
) (
  input  fsh_dir_e      dir_i,
  input  logic [W-1:0]  dst_i,
  input  logic [W-1:0]  src_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  res_o,
  output logic          cf_o
);
  logic [EW-1:0] l_w, r_w;

  // spare bit beyond the funnel catches the last bit shifted out
  assign l_w = {1'b0, dst_i, src_i} << cnt_i;
  assign r_w = {src_i, dst_i, 1'b0} >> cnt_i;

  always_comb begin
    if (dir_i == FSH_RIGHT) begin
      res_o = r_w[W:1];
      cf_o  = r_w[0];
    end else begin
      res_o = l_w[2*W-1:W];
      cf_o  = l_w[2*W];
    end
  end
endmodule

// File: rtl/fsh_flags.sv
module fsh_flags
  import funnel_pkg::*;
#(
  parameter int W  = 64,
  parameter int PW = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         dst_msb_i,
  input  logic         cf_i,
  output fsh_flags_t   flags_o
);
  always_comb begin
    flags_o.cf = cf_i;
    flags_o.of = res_i[W-1] ^ dst_msb_i;
    flags_o.zf = (res_i == '0);
    flags_o.sf = res_i[W-1];
    flags_o.pf = ~^res_i[PW-1:0];
  end
endmodule

// File: rtl/funnel_shift.sv
module funnel_shift
  import funnel_pkg::*;
#(
  parameter int W    = 64,
  parameter int IN_W = 8,
  parameter int PW   = 8,
  localparam int CW  = $clog2(W),
  localparam int NF  = $bits(fsh_flags_t)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            dir_i,
  input  logic            use_imm_i,
  input  logic [IN_W-1:0] imm_i,
  input  logic [IN_W-1:0] cnt_reg_i,
  input  logic [W-1:0]    dst_i,
  input  logic [W-1:0]    src_i,
  output logic            valid_o,
  output logic            wr_en_o,
  output logic [W-1:0]    result_o,
  output logic            cf_o,
  output logic            of_o,
  output logic            zf_o,
  output logic            sf_o,
  output logic            pf_o,
  output logic [NF-1:0]   flag_we_o
);
  logic [CW-1:0] cnt;
  logic          cnt_zero, cnt_one, core_cf, do_op;
  logic [W-1:0]  res_d;
  fsh_flags_t    flg_d, flg_q, we_d, we_q;

  fsh_count_sel #(.IN_W(IN_W), .W(W)) u_cnt (
    .use_imm_i(use_imm_i), .imm_i(imm_i), .creg_i(cnt_reg_i),
    .cnt_o(cnt), .zero_o(cnt_zero), .one_o(cnt_one)
  );

  fsh_core #(.W(W)) u_core (
    .dir_i(fsh_dir_e'(dir_i)), .dst_i(dst_i), .src_i(src_i),
    .cnt_i(cnt), .res_o(res_d), .cf_o(core_cf)
  );

  fsh_flags #(.W(W), .PW(PW)) u_flags (
    .res_i(res_d), .dst_msb_i(dst_i[W-1]), .cf_i(core_cf), .flags_o(flg_d)
  );

  assign do_op = valid_i & ~cnt_zero;

  always_comb begin
    we_d    = '0;
    if (do_op) begin
      we_d    = '1;
      we_d.of = cnt_one;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flg_q    <= '0;
      we_q     <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= do_op;
      we_q    <= we_d;
      if (do_op) result_o <= res_d;
      if (we_d.cf) flg_q.cf <= flg_d.cf;
      if (we_d.of) flg_q.of <= flg_d.of;
      if (we_d.zf) flg_q.zf <= flg_d.zf;
      if (we_d.sf) flg_q.sf <= flg_d.sf;
      if (we_d.pf) flg_q.pf <= flg_d.pf;
    end
  end

  assign cf_o      = flg_q.cf;
  assign of_o      = flg_q.of;
  assign zf_o      = flg_q.zf;
  assign sf_o      = flg_q.sf;
  assign pf_o      = flg_q.pf;
  assign flag_we_o = we_q;

  a_r2_noop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_zero) |=> (!wr_en_o && flag_we_o == '0));

  a_r2_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable(result_o));

  a_r6_of_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_o[1] |-> $stable(of_o));

  a_r7_sign_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (sf_o == result_o[W-1]));

  a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (zf_o == (result_o == '0)));

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wr_en_o));
endmodule

// File: tb/funnel_shift_tb.sv
`timescale 1ns/1ps
module funnel_shift_tb;
  localparam int W = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, dir_i = 1'b0, use_imm_i = 1'b0;
  logic [7:0]  imm_i = '0, cnt_reg_i = '0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic        valid_o, wr_en_o, cf_o, of_o, zf_o, sf_o, pf_o;
  logic [63:0] result_o;
  logic [4:0]  flag_we_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [63:0] e_res = '0;
  logic        e_cf = 0, e_of = 0, e_zf = 0, e_sf = 0, e_pf = 0;

  always #5 clk_i = ~clk_i;

  funnel_shift u_dut (
    .clk_i, .rst_ni, .valid_i, .dir_i, .use_imm_i, .imm_i, .cnt_reg_i,
    .dst_i, .src_i, .valid_o, .wr_en_o, .result_o, .cf_o, .of_o, .zf_o,
    .sf_o, .pf_o, .flag_we_o
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_res(input bit right, input logic [63:0] d,
                                          input logic [63:0] s, input int c);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (!right) r[i] = (i >= c) ? d[i-c] : s[64-c+i];
      else        r[i] = (i + c < 64) ? d[i+c] : s[i+c-64];
    end
    return r;
  endfunction

  function automatic bit ref_par(input logic [63:0] r);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(r[i]);
    return (n % 2) == 0;
  endfunction

  task automatic do_op(input bit right, input bit use_imm, input logic [7:0] imm,
                       input logic [7:0] creg, input logic [63:0] d,
                       input logic [63:0] s);
    int c;
    logic [63:0] r;
    logic [4:0] e_we;
    @(negedge clk_i);
    valid_i = 1; dir_i = right; use_imm_i = use_imm; imm_i = imm;
    cnt_reg_i = creg; dst_i = d; src_i = s;
    @(negedge clk_i);
    valid_i = 0;
    c = int'((use_imm ? imm : creg) & 8'd63);
    e_we = 5'b0;
    if (c != 0) begin
      r = ref_res(right, d, s, c);
      e_res = r;
      e_cf = right ? d[c-1] : d[64-c];
      e_zf = (r == 0);
      e_sf = r[63];
      e_pf = ref_par(r);
      e_we = 5'b11101;
      if (c == 1) begin
        e_of = r[63] ^ d[63];
        e_we[1] = 1'b1;
      end
    end
    chk(valid_o == 1, "R9 valid_o", 64'(valid_o), 64'd1);
    chk(wr_en_o == (c != 0), c == 0 ? "R2 wr_en" : "R8 wr_en", 64'(wr_en_o), 64'(c != 0));
    chk(flag_we_o == e_we, c == 0 ? "R2 flag_we" : "R8 flag_we", 64'(flag_we_o), 64'(e_we));
    chk(result_o == e_res, right ? "R4 R1 result" : "R3 R1 result", result_o, e_res);
    chk(cf_o == e_cf, "R5 carry", 64'(cf_o), 64'(e_cf));
    chk(of_o == e_of, "R6 overflow", 64'(of_o), 64'(e_of));
    chk(zf_o == e_zf, "R7 zero", 64'(zf_o), 64'(e_zf));
    chk(sf_o == e_sf, "R7 sign", 64'(sf_o), 64'(e_sf));
    chk(pf_o == e_pf, "R7 parity", 64'(pf_o), 64'(e_pf));
  endtask

  task automatic idle_check();
    @(negedge clk_i);
    chk(valid_o == 0 && wr_en_o == 0 && flag_we_o == 0, "R9 idle strobes",
        {61'd0, valid_o, wr_en_o, |flag_we_o}, 64'd0);
    chk(result_o == e_res && of_o == e_of && cf_o == e_cf, "R9 idle hold",
        result_o, e_res);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk_i);
    // R10 reset state
    chk(valid_o == 0 && wr_en_o == 0 && flag_we_o == 0, "R10 reset strobes",
        {61'd0, valid_o, wr_en_o, |flag_we_o}, 64'd0);
    chk(result_o == 0 && {cf_o, of_o, zf_o, sf_o, pf_o} == 0, "R10 reset data",
        result_o | 64'({cf_o, of_o, zf_o, sf_o, pf_o}), 64'd0);
    rst_ni = 1;

    // R6: set overflow, then longer shifts must leave it alone
    do_op(0, 1, 8'd1, 8'd0, 64'h4000_0000_0000_0000, 64'h0);
    do_op(0, 1, 8'd2, 8'd0, 64'h4000_0000_0000_0000, 64'h0);
    do_op(1, 0, 8'd0, 8'd7, 64'h8000_0000_0000_0001, rnd64());
    // R2: masked zero count (64) and plain zero count
    do_op(0, 1, 8'd64, 8'd3, rnd64(), rnd64());
    do_op(1, 0, 8'd5, 8'd0, rnd64(), rnd64());
    // R1: 65 masks to 1; high bits of count register ignored
    do_op(1, 1, 8'd65, 8'd0, 64'h8000_0000_0000_0000, 64'h1);
    do_op(0, 0, 8'd0, 8'hC4, rnd64(), rnd64());
    // R7: all-zero result and parity of a known byte
    do_op(0, 1, 8'd8, 8'd0, 64'h0, 64'h0);
    do_op(1, 1, 8'd63, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    idle_check();

    for (int dir = 0; dir < 2; dir++) begin
      for (int c = 0; c < 64; c++) begin
        bit ui;
        logic [7:0] hi;
        ui = 1'($urandom);
        hi = 8'($urandom) & 8'hC0;
        do_op(dir[0], ui, ui ? (8'(c) | hi) : 8'($urandom),
              ui ? 8'($urandom) : (8'(c) | hi), rnd64(), rnd64());
        if (($urandom % 5) == 0)
          do_op(1'($urandom), 1, 8'd1, 8'd0, rnd64(), rnd64());
      end
    end
    idle_check();

    for (int k = 0; k < 200; k++)
      do_op(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), rnd64(), rnd64());
    idle_check();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule